// File: doc/BRIEF.md
# Dual Reloading Timer with Interrupts

This block holds two independent down-counting timer channels behind a small synchronous 32-bit register port. Each channel has a reload value (the divider), a readable live count and a control word. The control word chooses what the channel does (load, hold or run) and which of four external tick strobes advances it. A running channel counts down once per selected strobe. When it expires it reloads from its divider, so it produces a steady periodic event.

Each expiry sets a sticky per-channel bit in a raw interrupt status register. Software enables bits through a mask register and clears them by writing ones to an acknowledge register. A masked status view shows the enabled pending bits. A single level interrupt line is high while any of them is set. The prescalers that make the tick strobes live outside the block.

Top module: `dual_tick_timer`

## Requirements
- R1: After reset both channels are in hold mode (control reads 0x1) with count and divider 0, and the raw status, the mask, the masked status and `irq_out` are all 0.
- R2: Writing control with mode bits [1:0] = 0 (load) copies the divider into the count on the next clock. The channel then does not count, whatever strobes arrive.
- R3: In hold mode (mode 1) the count stays fixed whatever strobes arrive.
- R4: In run mode (mode 2), control bits [4:2] pick the tick source. Codes 4, 5, 6 and 7 select `tick_strobe[0]`, `[1]`, `[2]` and `[3]`. Each cycle with the selected strobe high decrements the count by one. Codes 0 to 3 mean no counting, and strobes that are not selected have no effect.
- R5: A selected strobe that arrives while the count is 0 or 1 is an expiry. On an expiry the count reloads from the divider and raw status bit n is set for channel n (bit 0 for channel 0, bit 1 for channel 1). The bit stays set until it is acknowledged.
- R6: A control write with mode bits = 3 is ignored. Control, count and counting continue as if no write had occurred.
- R7: Writing the divider does not change the count. The new value is used only at the next load command or the next reload.
- R8: Writing the acknowledge register (0x4C) clears every raw bit written as 1 and leaves the others. The acknowledge register always reads 0.
- R9: If an expiry and an acknowledge of the same raw bit fall in the same cycle, the bit stays set.
- R10: The masked status (0x54) equals raw (0x50) AND mask (0x48, bits [1:0]). `irq_out` is high exactly when the masked status is nonzero.
- R11: An accepted control write wins over a strobe in the same cycle. That strobe neither decrements nor expires the channel.
- R12: Channel n has its divider at n*0x10+0x00, its count at n*0x10+0x04 (read only) and its control at n*0x10+0x08, which reads back bits [4:0]. Reads of unmapped addresses return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Byte address of the register access |
| bus_we | input | 1 | Write strobe for the addressed register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the addressed register, combinational |
| tick_strobe | input | 4 | Tick-enable strobes, one per selectable rate |
| irq_out | output | 1 | Level interrupt, high while any masked raw bit is set |

## Verification
The hardest cases to reach are those where two events meet in one clock cycle. One is a channel expiring in the same cycle its raw bit is acknowledged. Another is a control write landing on the cycle of a strobe. To reach them, the stimulus first sets the divider to 1 so that every selected strobe expires. It then drives the acknowledge write or the control write together with that strobe on a single edge. A random phase follows. It mixes strobes with writes of all four mode codes and all eight source codes against a reference model that is compared on every clock.

// File: rtl/dtt_pkg.sv
package dtt_pkg;

    localparam int ADDR_W   = 8;
    localparam int RATE_W   = 2;
    localparam int NUM_RATES = 1 << RATE_W;
    localparam int SRC_W    = RATE_W + 1;

    typedef enum logic [1:0] {
        MODE_LOAD = 2'd0,
        MODE_HOLD = 2'd1,
        MODE_RUN  = 2'd2,
        MODE_BAD  = 2'd3
    } mode_e;

    typedef struct packed {
        logic [SRC_W-1:0] src;
        mode_e            mode;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

    localparam ctrl_t CTRL_RESET = '{src: '0, mode: MODE_HOLD};

    localparam int CH_STRIDE = 'h10;
    localparam logic [ADDR_W-1:0] OFF_DIV   = 8'h00;
    localparam logic [ADDR_W-1:0] OFF_CNT   = 8'h04;
    localparam logic [ADDR_W-1:0] OFF_CTRL  = 8'h08;
    localparam logic [ADDR_W-1:0] ADR_MASK  = 8'h48;
    localparam logic [ADDR_W-1:0] ADR_ACK   = 8'h4C;
    localparam logic [ADDR_W-1:0] ADR_RAW   = 8'h50;
    localparam logic [ADDR_W-1:0] ADR_MSTAT = 8'h54;

    // Address of a channel register from channel index and offset
    function automatic logic [ADDR_W-1:0] chan_addr(input int ch, input logic [ADDR_W-1:0] off);
        return ADDR_W'(ch * CH_STRIDE) + off;
    endfunction

    // Selected strobe: upper source bit set picks one of the rate strobes
    function automatic logic src_tick(input logic [SRC_W-1:0] src,
                                      input logic [NUM_RATES-1:0] ticks);
        return src[SRC_W-1] ? ticks[src[RATE_W-1:0]] : 1'b0;
    endfunction

endpackage

// File: rtl/dtt_channel.sv
module dtt_channel
    import dtt_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 div_we,
    input  logic                 ctrl_we,
    input  logic [DATA_W-1:0]    wdata,
    input  logic [NUM_RATES-1:0] ticks,
    output logic [DATA_W-1:0]    div_q,
    output logic [DATA_W-1:0]    count_q,
    output ctrl_t                ctrl_q,
    output logic                 expire
);

    ctrl_t ctrl_in;
    logic  ctrl_ok;
    logic  step;

    always_comb begin
        ctrl_in = ctrl_t'(wdata[CTRL_W-1:0]);
        ctrl_ok = ctrl_we && (ctrl_in.mode != MODE_BAD);
        step    = (ctrl_q.mode == MODE_RUN) && src_tick(ctrl_q.src, ticks) && !ctrl_ok;
        expire  = step && (count_q <= DATA_W'(1));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            div_q   <= '0;
            count_q <= '0;
            ctrl_q  <= CTRL_RESET;
        end else begin
            if (div_we) begin
                div_q <= wdata;
            end
            if (ctrl_ok) begin
                ctrl_q <= ctrl_in;
                if (ctrl_in.mode == MODE_LOAD) begin
                    count_q <= div_q;
                end
            end else if (step) begin
                count_q <= expire ? div_q : count_q - DATA_W'(1);
            end
        end
    end

endmodule

// File: rtl/dtt_intc.sv
module dtt_intc #(
    parameter int NUM_CH = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NUM_CH-1:0] expire,
    input  logic              mask_we,
    input  logic              ack_we,
    input  logic [NUM_CH-1:0] wbits,
    output logic [NUM_CH-1:0] raw_q,
    output logic [NUM_CH-1:0] mask_q,
    output logic [NUM_CH-1:0] masked,
    output logic              irq
);

    logic [NUM_CH-1:0] clear_bits;

    always_comb begin
        clear_bits = ack_we ? wbits : '0;
        masked     = raw_q & mask_q;
        irq        = |masked;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            raw_q  <= '0;
            mask_q <= '0;
        end else begin
            raw_q <= (raw_q & ~clear_bits) | expire;
            if (mask_we) begin
                mask_q <= wbits;
            end
        end
    end

endmodule

// File: rtl/dtt_regif.sv
module dtt_regif
    import dtt_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int NUM_CH = 2
) (
    input  logic [ADDR_W-1:0]             bus_addr,
    input  logic                          bus_we,
    input  logic [NUM_CH-1:0][DATA_W-1:0] ch_div,
    input  logic [NUM_CH-1:0][DATA_W-1:0] ch_count,
    input  ctrl_t [NUM_CH-1:0]            ch_ctrl,
    input  logic [NUM_CH-1:0]             raw_q,
    input  logic [NUM_CH-1:0]             mask_q,
    input  logic [NUM_CH-1:0]             masked,
    output logic [NUM_CH-1:0]             div_we,
    output logic [NUM_CH-1:0]             ctrl_we,
    output logic                          mask_we,
    output logic                          ack_we,
    output logic [DATA_W-1:0]             rdata
);

    for (genvar g = 0; g < NUM_CH; g++) begin : g_dec
        assign div_we[g]  = bus_we && (bus_addr == chan_addr(g, OFF_DIV));
        assign ctrl_we[g] = bus_we && (bus_addr == chan_addr(g, OFF_CTRL));
    end

    assign mask_we = bus_we && (bus_addr == ADR_MASK);
    assign ack_we  = bus_we && (bus_addr == ADR_ACK);

    always_comb begin
        rdata = '0;
        for (int c = 0; c < NUM_CH; c++) begin
            if (bus_addr == chan_addr(c, OFF_DIV)) begin
                rdata = ch_div[c];
            end
            if (bus_addr == chan_addr(c, OFF_CNT)) begin
                rdata = ch_count[c];
            end
            if (bus_addr == chan_addr(c, OFF_CTRL)) begin
                rdata = DATA_W'(ch_ctrl[c]);
            end
        end
        case (bus_addr)
            ADR_MASK:  rdata = DATA_W'(mask_q);
            ADR_RAW:   rdata = DATA_W'(raw_q);
            ADR_MSTAT: rdata = DATA_W'(masked);
            default: ;
        endcase
    end

endmodule

// File: rtl/dual_tick_timer.sv
module dual_tick_timer
    import dtt_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int NUM_CH = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic                 bus_we,
    input  logic [DATA_W-1:0]    bus_wdata,
    output logic [DATA_W-1:0]    bus_rdata,
    input  logic [NUM_RATES-1:0] tick_strobe,
    output logic                 irq_out
);

    logic [NUM_CH-1:0][DATA_W-1:0] ch_div;
    logic [NUM_CH-1:0][DATA_W-1:0] ch_count;
    ctrl_t [NUM_CH-1:0]            ch_ctrl;
    logic [NUM_CH-1:0]             ch_expire;
    logic [NUM_CH-1:0]             div_we;
    logic [NUM_CH-1:0]             ctrl_we;
    logic                          mask_we;
    logic                          ack_we;
    logic [NUM_CH-1:0]             raw_q;
    logic [NUM_CH-1:0]             mask_q;
    logic [NUM_CH-1:0]             masked;

    dtt_regif #(.DATA_W(DATA_W), .NUM_CH(NUM_CH)) regif_i (
        .bus_addr (bus_addr),
        .bus_we   (bus_we),
        .ch_div   (ch_div),
        .ch_count (ch_count),
        .ch_ctrl  (ch_ctrl),
        .raw_q    (raw_q),
        .mask_q   (mask_q),
        .masked   (masked),
        .div_we   (div_we),
        .ctrl_we  (ctrl_we),
        .mask_we  (mask_we),
        .ack_we   (ack_we),
        .rdata    (bus_rdata)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        dtt_channel #(.DATA_W(DATA_W)) chan_i (
            .clk     (clk),
            .rst     (rst),
            .div_we  (div_we[g]),
            .ctrl_we (ctrl_we[g]),
            .wdata   (bus_wdata),
            .ticks   (tick_strobe),
            .div_q   (ch_div[g]),
            .count_q (ch_count[g]),
            .ctrl_q  (ch_ctrl[g]),
            .expire  (ch_expire[g])
        );
    end

    dtt_intc #(.NUM_CH(NUM_CH)) intc_i (
        .clk     (clk),
        .rst     (rst),
        .expire  (ch_expire),
        .mask_we (mask_we),
        .ack_we  (ack_we),
        .wbits   (bus_wdata[NUM_CH-1:0]),
        .raw_q   (raw_q),
        .mask_q  (mask_q),
        .masked  (masked),
        .irq     (irq_out)
    );

endmodule

// File: rtl/dtt_checker.sv
module dtt_checker
    import dtt_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int NUM_CH = 2
) (
    input logic                          clk,
    input logic                          rst,
    input logic                          irq_out,
    input logic [NUM_CH-1:0]             raw_q,
    input logic [NUM_CH-1:0]             mask_q,
    input logic [NUM_CH-1:0]             expire,
    input logic                          ack_we,
    input logic [NUM_CH-1:0]             ack_bits,
    input logic [NUM_CH-1:0]             ctrl_we,
    input logic [1:0]                    wmode,
    input logic [NUM_CH-1:0][CTRL_W-1:0] ch_ctrl,
    input logic [NUM_CH-1:0][DATA_W-1:0] ch_count
);

    AST_IRQ_NEEDS_MASK: assert property (@(posedge clk) disable iff (rst)
        irq_out |-> (mask_q != '0)); // R10

    for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
        AST_EXPIRY_SETS_RAW: assert property (@(posedge clk) disable iff (rst)
            expire[i] |=> raw_q[i]); // R9

        AST_RAW_STICKY: assert property (@(posedge clk) disable iff (rst)
            raw_q[i] && !(ack_we && ack_bits[i]) |=> raw_q[i]); // R5

        AST_RAW_NO_SPURIOUS: assert property (@(posedge clk) disable iff (rst)
            !raw_q[i] && !expire[i] |=> !raw_q[i]); // R5

        AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (rst)
            ack_we && ack_bits[i] && !expire[i] |=> !raw_q[i]); // R8

        AST_HOLD_FREEZES: assert property (@(posedge clk) disable iff (rst)
            (ch_ctrl[i][1:0] == 2'd1) && !ctrl_we[i] |=> $stable(ch_count[i])); // R3

        AST_BAD_MODE_IGNORED: assert property (@(posedge clk) disable iff (rst)
            ctrl_we[i] && (wmode == 2'd3) |=> $stable(ch_ctrl[i])); // R6
    end

endmodule

bind dual_tick_timer dtt_checker #(.DATA_W(DATA_W), .NUM_CH(NUM_CH)) chk_i (
    .clk      (clk),
    .rst      (rst),
    .irq_out  (irq_out),
    .raw_q    (raw_q),
    .mask_q   (mask_q),
    .expire   (ch_expire),
    .ack_we   (ack_we),
    .ack_bits (bus_wdata[NUM_CH-1:0]),
    .ctrl_we  (ctrl_we),
    .wmode    (bus_wdata[1:0]),
    .ch_ctrl  (ch_ctrl),
    .ch_count (ch_count)
);

// File: tb/dual_tick_timer_tb.sv
`timescale 1ns/1ps
module dual_tick_timer_tb_top;

    logic        clk = 1'b0;
    logic        rst;
    logic [7:0]  bus_addr;
    logic        bus_we;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata;
    logic [3:0]  tick_strobe;
    logic        irq_out;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    // reference model state
    logic [31:0] m_div [2];
    logic [31:0] m_cnt [2];
    int          m_mode [2];
    int          m_src [2];
    logic [1:0]  m_raw;
    logic [1:0]  m_mask;

    always #4 clk = ~clk;

    dual_tick_timer dut_i (
        .clk         (clk),
        .rst         (rst),
        .bus_addr    (bus_addr),
        .bus_we      (bus_we),
        .bus_wdata   (bus_wdata),
        .bus_rdata   (bus_rdata),
        .tick_strobe (tick_strobe),
        .irq_out     (irq_out)
    );

    function automatic logic [31:0] model_read(input logic [7:0] a);
        for (int c = 0; c < 2; c++) begin
            if (a == 8'(c * 16))     return m_div[c];
            if (a == 8'(c * 16 + 4)) return m_cnt[c];
            if (a == 8'(c * 16 + 8)) return 32'((m_src[c] << 2) | m_mode[c]);
        end
        case (a)
            8'h48:   return {30'd0, m_mask};
            8'h50:   return {30'd0, m_raw};
            8'h54:   return {30'd0, m_raw & m_mask};
            default: return 32'd0;
        endcase
    endfunction

    always @(posedge clk) begin
        logic [1:0] e;
        if (rst) begin
            for (int c = 0; c < 2; c++) begin
                m_div[c] = 0; m_cnt[c] = 0; m_mode[c] = 1; m_src[c] = 0;
            end
            m_raw = 0; m_mask = 0;
        end else begin
            e = 0;
            for (int c = 0; c < 2; c++) begin
                if (bus_we && bus_addr == 8'(c * 16 + 8) && bus_wdata[1:0] != 2'd3) begin
                    m_mode[c] = int'(bus_wdata[1:0]);
                    m_src[c]  = int'(bus_wdata[4:2]);
                    if (m_mode[c] == 0) m_cnt[c] = m_div[c];
                end else if (m_mode[c] == 2 && m_src[c] >= 4 && tick_strobe[m_src[c] - 4]) begin
                    if (m_cnt[c] <= 1) begin
                        m_cnt[c] = m_div[c];
                        e[c] = 1'b1;
                    end else begin
                        m_cnt[c] = m_cnt[c] - 1;
                    end
                end
                if (bus_we && bus_addr == 8'(c * 16)) m_div[c] = bus_wdata;
            end
            if (bus_we && bus_addr == 8'h4C) m_raw = m_raw & ~bus_wdata[1:0];
            m_raw = m_raw | e;
            if (bus_we && bus_addr == 8'h48) m_mask = bus_wdata[1:0];
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // per-clock comparison against the model
    always @(negedge clk) begin
        if (!rst && !done) begin
            chk(irq_out === |(m_raw & m_mask), "R10 model irq", {31'd0, irq_out}, {31'd0, |(m_raw & m_mask)});
            chk(bus_rdata === model_read(bus_addr), "R12 model read", bus_rdata, model_read(bus_addr));
        end
    end

    task automatic step(input logic we, input logic [7:0] a, input logic [31:0] d, input logic [3:0] tk);
        @(posedge clk);
        #2;
        bus_we = we; bus_addr = a; bus_wdata = d; tick_strobe = tk;
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        step(1'b1, a, d, 4'h0);
    endtask

    task automatic tk(input logic [3:0] t);
        step(1'b0, 8'h00, 32'h0, t);
    endtask

    task automatic expect_rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
        step(1'b0, a, 32'h0, 4'h0);
        @(negedge clk);
        chk(bus_rdata === exp, tag, bus_rdata, exp);
    endtask

    task automatic expect_irq(input logic exp, input string tag);
        @(negedge clk);
        chk(irq_out === exp, tag, {31'd0, irq_out}, {31'd0, exp});
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; bus_we = 0; bus_addr = 0; bus_wdata = 0; tick_strobe = 0;
        repeat (3) @(posedge clk);
        #2 rst = 1'b0;

        // R1 reset state
        expect_rd(8'h08, 32'h1, "R1 ctrl0 reset");
        expect_rd(8'h18, 32'h1, "R1 ctrl1 reset");
        expect_rd(8'h04, 32'h0, "R1 count0 reset");
        expect_rd(8'h50, 32'h0, "R1 raw reset");
        expect_rd(8'h48, 32'h0, "R1 mask reset");
        expect_irq(1'b0, "R1 irq reset");

        // R7 divider write alone leaves count
        wr(8'h00, 32'd3);
        expect_rd(8'h04, 32'd0, "R7 count after div write");
        expect_rd(8'h00, 32'd3, "R12 div0 readback");

        // R2 load
        wr(8'h08, 32'h0);
        expect_rd(8'h04, 32'd3, "R2 count loaded");
        tk(4'hF); tk(4'hF); tk(4'hF);
        expect_rd(8'h04, 32'd3, "R2 load mode no count");

        // R4 run on strobe 0
        wr(8'h08, 32'h12);
        tk(4'b0001);
        expect_rd(8'h04, 32'd2, "R4 decrement");
        tk(4'b0010);
        expect_rd(8'h04, 32'd2, "R4 unselected strobe");
        tk(4'b0001); tk(4'b0001);
        expect_rd(8'h04, 32'd3, "R5 reload on expiry");
        expect_rd(8'h50, 32'h1, "R5 raw bit0 set");
        expect_rd(8'h54, 32'h0, "R10 masked with mask 0");
        expect_irq(1'b0, "R10 irq masked off");

        wr(8'h48, 32'h3);
        expect_rd(8'h54, 32'h1, "R10 masked after enable");
        expect_irq(1'b1, "R10 irq high");

        // R6 illegal mode
        wr(8'h08, 32'h13);
        expect_rd(8'h08, 32'h12, "R6 ctrl unchanged");
        expect_rd(8'h04, 32'd3, "R6 count unchanged");

        // R3 hold
        wr(8'h08, 32'h11);
        tk(4'b0001); tk(4'b0001); tk(4'b0001);
        expect_rd(8'h04, 32'd3, "R3 hold freezes");
        expect_rd(8'h50, 32'h1, "R5 raw stays set");

        // R8 acknowledge
        wr(8'h4C, 32'h1);
        expect_rd(8'h50, 32'h0, "R8 raw cleared");
        expect_irq(1'b0, "R8 irq low after ack");
        expect_rd(8'h4C, 32'h0, "R8 ack reads zero");

        // R7 divider change takes effect at reload
        wr(8'h08, 32'h12);
        wr(8'h00, 32'd5);
        expect_rd(8'h04, 32'd3, "R7 count kept");
        tk(4'b0001); tk(4'b0001); tk(4'b0001);
        expect_rd(8'h04, 32'd5, "R7 new divider at reload");
        wr(8'h4C, 32'h1);

        // R11 control write beats strobe
        step(1'b1, 8'h08, 32'h12, 4'b0001);
        expect_rd(8'h04, 32'd5, "R11 strobe dropped");

        // R9 expiry and ack together
        wr(8'h10, 32'd1);
        wr(8'h18, 32'h1E);
        tk(4'b1000);
        expect_rd(8'h50, 32'h2, "R5 raw bit1 set");
        step(1'b1, 8'h4C, 32'h2, 4'b1000);
        expect_rd(8'h50, 32'h2, "R9 expiry wins over ack");
        wr(8'h4C, 32'h2);
        expect_rd(8'h50, 32'h0, "R8 raw bit1 cleared");

        // R4 disabled source code 0
        wr(8'h18, 32'h02);
        tk(4'hF); tk(4'hF);
        expect_rd(8'h14, 32'd1, "R4 source 0 does not count");
        // R4 source code 5 selects strobe 1
        wr(8'h18, 32'h16);
        tk(4'b0010);
        expect_rd(8'h50, 32'h2, "R4 code 5 uses strobe 1");
        expect_rd(8'h30, 32'h0, "R12 unmapped reads zero");

        // random phase, model compared every clock
        for (int i = 0; i < 600; i++) begin
            logic [7:0]  a;
            logic [31:0] d;
            int sel;
            sel = $urandom_range(0, 7);
            case (sel)
                0: a = 8'h00; 1: a = 8'h08; 2: a = 8'h10; 3: a = 8'h18;
                4: a = 8'h48; 5: a = 8'h4C; 6: a = 8'h04; default: a = 8'h14;
            endcase
            d = (a == 8'h00 || a == 8'h10) ? 32'($urandom_range(0, 6)) : 32'($urandom_range(0, 31));
            step(($urandom_range(0, 3) == 0), a, d, 4'($urandom_range(0, 15)));
        end
        step(1'b0, 8'h50, 32'h0, 4'h0);
        @(negedge clk);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule